// File: doc/BRIEF.md
# Keyboard Controller Power-up Sequencer

This block steps an 8-bit keyboard and mouse controller from reset release to the point where its serial interfaces are open. After reset it drives a fixed pattern on two output ports and runs a timed delay. At the end of the delay it samples two strap pins once. If both straps are low it selects PS/2 mode; otherwise it selects AT mode.

It then drives a mode-dependent wait pattern and watches host data-port writes, each presented as a byte with a one-cycle strobe. When the self-test command arrives, it issues a one-cycle load of the pass reply into the output buffer. It then drives the open pattern, which enables keyboard reception (and mouse reception in PS/2 mode). Serial reception and scan-code translation live elsewhere; this block only sequences.

Top module: `kbcseq_top`

## Requirements
- R1: While reset is held, `ctl_port_a` = 0x00, `ctl_port_b` = 0x88 (bits 7 and 3 high), `ps2_mode` = 0 and `obuf_load` = 0.
- R2: After reset release, the drive pattern of R1 lasts exactly DELAY_CYC = CLK_HZ/1e6 × DELAY_US clock edges; the wait pattern appears after edge DELAY_CYC.
- R3: If both straps are low at the sampling edge, `ps2_mode` becomes 1 and the wait pattern is `ctl_port_a` = 0xFF, `ctl_port_b` = 0x4B (bits 7, 5, 4 and 2 low).
- R4: If either strap is high at the sampling edge, `ps2_mode` stays 0 and the wait pattern is `ctl_port_a` = 0xFF, `ctl_port_b` = 0xCF (bits 5 and 4 low).
- R5: During the wait phase, host writes of any byte other than 0xAA leave both ports, `ps2_mode` and `obuf_load` unchanged.
- R6: A host write of 0xAA during the wait phase raises `obuf_load` for exactly one cycle, after the next edge, with `obuf_data` = 0x55. In that same cycle `ctl_port_b` bit 4 (the output-buffer-full mirror) is high.
- R7: After the command, the open pattern holds. `ctl_port_a` = 0xFF. `ctl_port_b` = 0x9F in AT mode (bit 4 high, bits 6 and 5 low). `ctl_port_b` = 0x13 in PS/2 mode (bit 4 high, bits 7, 6, 5, 3 and 2 low).
- R8: Host writes during the drive phase (including 0xAA on the very edge that ends the delay) and any write after the open pattern is reached cause no load and no port change.
- R9: Asserting reset at any phase restores the R1 state and restarts the delay in full.
- R10: Once the mode is chosen, later changes on the straps do not change `ps2_mode` or the port patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_sel_a | input | 1 | First mode strap |
| strap_sel_b | input | 1 | Second mode strap |
| host_wr | input | 1 | One-cycle host data-port write strobe |
| host_data | input | 8 | Byte written by the host |
| ctl_port_a | output | 8 | Drive value of the first controller port |
| ctl_port_b | output | 8 | Drive value of the second controller port |
| obuf_load | output | 1 | One-cycle output-buffer load request |
| obuf_data | output | 8 | Byte to load into the output buffer |
| ps2_mode | output | 1 | 1 when PS/2 mode was selected |

## Verification
The end of the delay and a host self-test command can land on the same clock edge. The bench provokes this by strobing 0xAA exactly on edge DELAY_CYC. At that edge the block is still in its drive phase, so the command must be dropped. The bench judges this by the absence of any load (its scoreboard holds no expected item) and by the port showing the plain wait pattern on the next cycle and three cycles later. A reset applied in the same cycle the straps are being resampled is also exercised, to show that the delay restarts from zero.

// File: rtl/kbcseq_pkg.sv
package kbcseq_pkg;

   typedef enum logic [1:0] {
      PH_DRIVE = 2'd0,
      PH_WAIT  = 2'd1,
      PH_OPEN  = 2'd2
   } phase_e;

   // Bit roles on the second port; neighbours decode these positions.
   localparam int B_MSAUX   = 7;
   localparam int B_KBINH   = 6;
   localparam int B_AUXOBF  = 5;
   localparam int B_OBF     = 4;
   localparam int B_MSINH   = 3;
   localparam int B_MSCLK   = 2;
   localparam int PORT_W    = 8;

endpackage

// File: rtl/kbcseq_timer.sv
module kbcseq_timer #(
   parameter int CYCLES = 48000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   assign expired = run && (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (run && !expired)   cnt <= cnt + 1'b1;
   end

   a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/kbcseq_strap.sv
module kbcseq_strap #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_a,
   input  logic pin_b,
   input  logic take,
   output logic ps2_mode
);
   logic sa_q, sb_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign sa_q = pin_a;
         assign sb_q = pin_b;
      end else begin : g_sync
         logic [STAGES-1:0] ra, rb;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ra <= '1;
               rb <= '1;
            end else begin
               ra[0] <= pin_a;
               rb[0] <= pin_b;
               for (int i = 1; i < STAGES; i++) begin
                  ra[i] <= ra[i-1];
                  rb[i] <= rb[i-1];
               end
            end
         end
         assign sa_q = ra[STAGES-1];
         assign sb_q = rb[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ps2_mode <= 1'b0;
      else if (take)  ps2_mode <= ~sa_q & ~sb_q;
   end

   a_r10_mode_only_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(ps2_mode));

endmodule

// File: rtl/kbcseq_portmap.sv
module kbcseq_portmap
   import kbcseq_pkg::*;
(
   input  phase_e            phase,
   input  logic              ps2,
   output logic [PORT_W-1:0] port_a,
   output logic [PORT_W-1:0] port_b
);
   always_comb begin
      port_a = '1;
      port_b = '1;
      unique case (phase)
         PH_DRIVE: begin
            port_a = '0;
            port_b = '0;
            port_b[B_MSAUX] = 1'b1;
            port_b[B_MSINH] = 1'b1;
         end
         PH_WAIT, PH_OPEN: begin
            port_b[B_OBF]    = 1'b0;
            port_b[B_AUXOBF] = 1'b0;
            if (ps2) begin
               port_b[B_MSCLK] = 1'b0;
               port_b[B_MSAUX] = 1'b0;
            end
            if (phase == PH_OPEN) begin
               port_b[B_OBF]   = 1'b1;
               port_b[B_KBINH] = 1'b0;
               if (ps2) port_b[B_MSINH] = 1'b0;
            end
         end
         default: begin
            port_a = '1;
            port_b = '1;
         end
      endcase
   end
endmodule

// File: rtl/kbcseq_top.sv
module kbcseq_top
   import kbcseq_pkg::*;
#(
   parameter int          CLK_HZ         = 8_000_000,
   parameter int          DELAY_US       = 6000,
   parameter int          SYNC_STAGES    = 2,
   parameter logic [7:0]  SELFTEST_CMD   = 8'hAA,
   parameter logic [7:0]  SELFTEST_REPLY = 8'h55
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap_sel_a,
   input  logic       strap_sel_b,
   input  logic       host_wr,
   input  logic [7:0] host_data,
   output logic [7:0] ctl_port_a,
   output logic [7:0] ctl_port_b,
   output logic       obuf_load,
   output logic [7:0] obuf_data,
   output logic       ps2_mode
);
   localparam int TICKS_PER_US = CLK_HZ / 1_000_000;
   localparam int DELAY_CYC    = TICKS_PER_US * DELAY_US;

   initial begin
      a_cfg_clk: assert (CLK_HZ % 1_000_000 == 0 && CLK_HZ > 0)
         else $error("CLK_HZ must be a whole number of MHz");
      a_cfg_delay: assert (DELAY_CYC >= SYNC_STAGES + 2)
         else $error("delay too short for strap synchroniser");
      a_cfg_sync: assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4)
         else $error("SYNC_STAGES out of range");
   end

   phase_e phase;
   logic   expired;

   kbcseq_timer #(.CYCLES(DELAY_CYC)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (phase == PH_DRIVE),
      .expired (expired)
   );

   kbcseq_strap #(.STAGES(SYNC_STAGES)) u_strap (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_a    (strap_sel_a),
      .pin_b    (strap_sel_b),
      .take     (expired),
      .ps2_mode (ps2_mode)
   );

   kbcseq_portmap u_map (
      .phase  (phase),
      .ps2    (ps2_mode),
      .port_a (ctl_port_a),
      .port_b (ctl_port_b)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_DRIVE;
         obuf_load <= 1'b0;
         obuf_data <= '0;
      end else begin
         obuf_load <= 1'b0;
         unique case (phase)
            PH_DRIVE: if (expired) phase <= PH_WAIT;
            PH_WAIT: if (host_wr && host_data == SELFTEST_CMD) begin
               phase     <= PH_OPEN;
               obuf_load <= 1'b1;
               obuf_data <= SELFTEST_REPLY;
            end
            default: phase <= PH_OPEN;
         endcase
      end
   end

   a_r6_load_single: assert property (@(posedge clk) disable iff (!rst_n)
      obuf_load |=> !obuf_load);

   a_r6_obf_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      obuf_load |-> (ctl_port_b[B_OBF] && obuf_data == SELFTEST_REPLY));

   a_r8_open_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_OPEN) |=> (phase == PH_OPEN && !obuf_load));

   a_r1_drive_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_DRIVE) |-> (!ps2_mode && !obuf_load));

   a_r10_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_DRIVE) |=> $stable(ps2_mode));

endmodule

// File: tb/tb_kbcseq_top.sv
module tb_kbcseq_top;
   localparam int DLY_US = 2;
   localparam int DLY    = 8 * DLY_US;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       sa = 1'b1, sb = 1'b1, wr = 1'b0;
   logic [7:0] wd = 8'h00;
   logic [7:0] pa, pb, od;
   logic       ld, ps2;

   kbcseq_top #(.DELAY_US(DLY_US)) dut (
      .clk(clk), .rst_n(rst_n), .strap_sel_a(sa), .strap_sel_b(sb),
      .host_wr(wr), .host_data(wd), .ctl_port_a(pa), .ctl_port_b(pb),
      .obuf_load(ld), .obuf_data(od), .ps2_mode(ps2));

   always #4 clk = ~clk;

   int         n_chk = 0, n_bad = 0;
   bit         fin = 1'b0;
   logic [7:0] expq[$];
   logic [7:0] e;

   task automatic chk8(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(2);
      rst_n = 1'b1;
   endtask

   task automatic wr_byte(logic [7:0] b, bit expect_load);
      wr = 1'b1;
      wd = b;
      if (expect_load) expq.push_back(8'h55);
      tick(1);
      wr = 1'b0;
   endtask

   // Monitor: every load must match a queued expectation
   always @(negedge clk) begin
      if (rst_n && ld) begin
         if (expq.size() == 0) chk8("R8 unexpected load", 8'h01, 8'h00);
         else begin
            e = expq.pop_front();
            chk8("R6 reply byte", od, e);
            chk8("R6 obf bit high", {7'b0, pb[4]}, 8'h01);
         end
      end
   end

   initial begin
      // R1 reset state, AT straps (a high)
      sa = 1'b1; sb = 1'b0;
      rst_n = 1'b0;
      tick(2);
      chk8("R1 port a", pa, 8'h00);
      chk8("R1 port b", pb, 8'h88);
      chk8("R1 mode", {7'b0, ps2}, 8'h00);
      chk8("R1 load", {7'b0, ld}, 8'h00);
      rst_n = 1'b1;
      tick(3);
      wr_byte(8'hAA, 1'b0);                 // R8 command during drive
      tick(DLY - 1 - 4);
      chk8("R2 still drive", pb, 8'h88);
      chk8("R8 drive write ignored a", pa, 8'h00);
      tick(1);
      chk8("R2/R4 wait pattern b", pb, 8'hCF);
      chk8("R4 port a", pa, 8'hFF);
      chk8("R4 mode AT", {7'b0, ps2}, 8'h00);
      wr_byte(8'h00, 1'b0);
      wr_byte(8'h55, 1'b0);
      wr_byte(8'hAB, 1'b0);
      tick(1);
      chk8("R5 other bytes ignored", pb, 8'hCF);
      chk8("R5 mode unchanged", {7'b0, ps2}, 8'h00);
      wr_byte(8'hAA, 1'b1);
      tick(1);
      chk8("R7 AT open b", pb, 8'h9F);
      chk8("R7 AT open a", pa, 8'hFF);
      chk8("R6 load consumed", 8'(expq.size()), 8'h00);
      wr_byte(8'hAA, 1'b0);                 // R8 after open
      tick(2);
      chk8("R8 open stays", pb, 8'h9F);

      // R3 PS/2 run
      sa = 1'b0; sb = 1'b0;
      do_reset();
      tick(DLY);
      chk8("R3 mode PS2", {7'b0, ps2}, 8'h01);
      chk8("R3 wait b", pb, 8'h4B);
      sa = 1'b1;
      tick(4);
      chk8("R10 mode frozen", {7'b0, ps2}, 8'h01);
      chk8("R10 pattern frozen", pb, 8'h4B);
      wr_byte(8'hAA, 1'b1);
      tick(1);
      chk8("R7 PS2 open b", pb, 8'h13);
      rst_n = 1'b0;
      tick(1);
      chk8("R9 reset from open b", pb, 8'h88);
      chk8("R9 reset clears mode", {7'b0, ps2}, 8'h00);
      chk8("R9 reset a", pa, 8'h00);
      rst_n = 1'b1;

      // R9 reset in mid drive restarts delay
      sa = 1'b0; sb = 1'b0;
      do_reset();
      tick(10);
      rst_n = 1'b0;
      tick(1);
      rst_n = 1'b1;
      tick(DLY - 1);
      chk8("R9 delay restarted", pb, 8'h88);
      tick(1);
      chk8("R9 wait after full delay", pb, 8'h4B);

      // Collision: command on the expiring edge (R8), straps high (R4)
      sa = 1'b1; sb = 1'b1;
      do_reset();
      tick(DLY - 1);
      wr_byte(8'hAA, 1'b0);
      chk8("R8 collision dropped b", pb, 8'hCF);
      chk8("R4 both high AT", {7'b0, ps2}, 8'h00);
      tick(3);
      chk8("R8 collision still wait", pb, 8'hCF);
      wr_byte(8'hAA, 1'b1);
      tick(1);
      chk8("R7 open after retry", pb, 8'h9F);
      chk8("R6 queue drained", 8'(expq.size()), 8'h00);

      fin = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!fin) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements) act=running exp=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
         $finish;
      end
   end
endmodule